// File: doc/BRIEF.md
# Sectioned control register access controller

This block is the access engine for a 64-address clock and control register space. A transaction layer in front of it (for example a serial-bus slave) opens a transaction with a start pulse, optionally loads a new address, moves data bytes over two valid/ready streams, and closes the transaction with a stop pulse. The space is split into five sections: two 8-byte alarm banks, a 4-byte control bank, an 8-byte time bank and a single status byte. Within one transaction the address never leaves the section it started in.

Writes are staged rather than applied directly. The staged bytes are committed only when the stop arrives. For every section except status, the two write-enable bits in the status byte must also both be set at that moment. The time bank counts seconds, minutes and hours from a one-pulse-per-second input. Every read transaction takes a copy of the time bank when it starts, so the bytes returned during the read are consistent with each other. The current address persists between transactions, which allows current-address reads.

Back-pressure follows plain valid/ready rules. A write byte moves on a clock edge where `wd_valid` and `wd_ready` are both high. A read byte moves on a clock edge where `rd_valid` and `rd_ready` are both high. While a side holds its stream low, `rd_data` and the address stay unchanged.

Top module: `ccr_access_ctrl`

## Requirements
- R1: Address map: 0x00-0x07 alarm bank 0, 0x08-0x0F alarm bank 1, 0x10-0x13 control, 0x30-0x37 time, 0x3F status; every other address is undefined. An undefined address reads 0x00, drops written bytes, and still advances the address by one (modulo 64).
- R2: After each transferred byte in a defined section, the address advances by one. From the last byte of that section it wraps to the section's first byte, so a transaction never leaves its section.
- R3: A start with `txn_use_addr`=1 loads `txn_addr`; with 0 it continues from the current address. The address left after a read is the last address read plus one, wrapped as in R2.
- R4: In the status section one byte moves per transaction. After it, `wd_ready` and `rd_valid` stay low until the next start.
- R5: Bytes written to the alarm, control or time sections are held back. They are committed together at stop only if WEL (status bit 1) and RWEL (status bit 2) are both 1 at that stop; otherwise they are discarded.
- R6: Writing the status byte takes effect at stop without RWEL. WEL takes written bit 1. RWEL becomes 1 only if written bits 2 and 1 are both 1 and WEL was already 1. Any other status write clears RWEL.
- R7: When a read transaction starts, the time bank is copied. Reads of 0x30-0x37 return that copy for the whole transaction, even if seconds tick meanwhile.
- R8: A start that arrives before the stop of a write transaction discards every byte staged in that transaction. The start has priority over a stop in the same cycle.
- R9: `wd_ready` is high only inside an open write transaction, and `rd_valid` only inside an open read transaction, both low in any cycle with `txn_start` or `txn_stop`. A byte that is not accepted leaves the address and `rd_data` unchanged.
- R10: Each `sec_tick` advances the time bank. Seconds (0x30) and minutes (0x31) wrap from 0x59 to 0x00 with a carry. Hours (0x32 bits 5:0) wrap from 0x23 to 0x00, keeping bits 7:6. Below the limit, a low digit of 9 becomes 0 and the high digit is incremented; otherwise the byte is incremented. A commit in the same cycle replaces the tick.
- R11: The status byte reads {ext_flags[2:0], 0, 0, RWEL, WEL, RTCF}. RTCF is 1 after reset and is cleared by any committed time write.
- R12: After reset every alarm, control and time byte is 0x00 except 0x37, which is 0x20. WEL, RWEL and the address are 0 and no transaction is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Opens a transaction (aborts an open one) |
| txn_read | input | 1 | With start: 1 read, 0 write |
| txn_use_addr | input | 1 | With start: 1 loads txn_addr |
| txn_addr | input | 6 | Start address |
| txn_stop | input | 1 | Closes the transaction, commits staged writes |
| wd_valid | input | 1 | Write byte offered |
| wd_data | input | 8 | Write byte |
| wd_ready | output | 1 | Write byte accepted this cycle |
| rd_valid | output | 1 | Read byte available |
| rd_data | output | 8 | Read byte at current address |
| rd_ready | input | 1 | Read byte taken this cycle |
| sec_tick | input | 1 | One pulse per second |
| ext_flags | input | 3 | Live flags shown in status bits 7:5 |

## Verification
The bench targets the wrap points of each section (0x07, 0x0F, 0x13, 0x37). A design that wraps over the whole space would return bytes from the next section. It locks the status byte after one transfer; a design that keeps streaming would accept a second status byte and corrupt the enable bits. It checks that writes are held until stop and dropped without both enable bits or on an abort, so a design that writes through would show changed alarm bytes after an abort. It also ticks a carry chain 0x58/0x59/0x23 during an open read: a design without the copy returns rolled-over time in the middle of the read, and a design with a broken carry shows the wrong minutes or hours afterwards.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int AW        = 6;
  localparam int DW        = 8;
  localparam int PAGE      = 8;
  localparam int IW        = $clog2(PAGE);
  localparam int CTL_N     = 4;
  localparam int CW        = $clog2(CTL_N);
  localparam int N_ALARMS  = 2;
  localparam logic [AW-1:0] STAT_ADDR = 6'h3F;
  localparam int CENT_IDX  = 7;
  localparam logic [DW-1:0] CENT_RST  = 8'h20;
  localparam logic [DW-1:0] LIM_SM    = 8'h59;
  localparam logic [DW-1:0] LIM_HR    = 8'h23;
  localparam int WEL_BIT   = 1;
  localparam int RWEL_BIT  = 2;

  typedef enum logic [2:0] {
    SEC_AL0  = 3'd0,
    SEC_AL1  = 3'd1,
    SEC_CTL  = 3'd2,
    SEC_TIME = 3'd3,
    SEC_STAT = 3'd4,
    SEC_NONE = 3'd5
  } sect_e;

  function automatic sect_e sect_of(input logic [AW-1:0] a);
    if (a[5:3] == 3'b000)       return SEC_AL0;
    else if (a[5:3] == 3'b001)  return SEC_AL1;
    else if (a[5:2] == 4'b0100) return SEC_CTL;
    else if (a[5:3] == 3'b110)  return SEC_TIME;
    else if (a == STAT_ADDR)    return SEC_STAT;
    else                        return SEC_NONE;
  endfunction

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
    case (sect_of(a))
      SEC_AL0, SEC_AL1, SEC_TIME: return {a[5:3], a[2:0] + 3'd1};
      SEC_CTL:                    return {a[5:2], a[1:0] + 2'd1};
      SEC_STAT:                   return a;
      default:                    return a + 6'd1;
    endcase
  endfunction

  // {carry, next value}
  function automatic logic [DW:0] bcd_step(input logic [DW-1:0] v, input logic [DW-1:0] lim);
    if (v == lim)              return {1'b1, 8'h00};
    else if (v[3:0] == 4'd9)   return {1'b0, v[7:4] + 4'd1, 4'd0};
    else                       return {1'b0, v + 8'd1};
  endfunction
endpackage

// File: rtl/ccr_stage_buf.sv
module ccr_stage_buf
  import ccr_pkg::*;
#(
  parameter int DEPTH = PAGE,
  localparam int XW = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [XW-1:0]              idx,
  input  logic [DW-1:0]              wdata,
  input  sect_e                      sect_in,
  output logic [DEPTH-1:0][DW-1:0]   data_q,
  output logic [DEPTH-1:0]           mask_q,
  output sect_e                      sect_q
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[i] <= '0;
        mask_q[i] <= 1'b0;
      end else if (clr) begin
        mask_q[i] <= 1'b0;
      end else if (wr_en && idx == XW'(i)) begin
        data_q[i] <= wdata;
        mask_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sect_q <= SEC_NONE;
    else if (wr_en) sect_q <= sect_in;
  end
endmodule

// File: rtl/ccr_nv_bank.sv
module ccr_nv_bank
  import ccr_pkg::*;
(
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    commit_en,
  input  sect_e                                   commit_sect,
  input  logic [PAGE-1:0][DW-1:0]                 stg_data,
  input  logic [PAGE-1:0]                         stg_mask,
  output logic [N_ALARMS-1:0][PAGE-1:0][DW-1:0]   al_q,
  output logic [CTL_N-1:0][DW-1:0]                ctl_q
);
  for (genvar k = 0; k < N_ALARMS; k++) begin : g_alarm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        al_q[k] <= '0;
      end else if (commit_en && commit_sect == sect_e'(k)) begin
        for (int i = 0; i < PAGE; i++)
          if (stg_mask[i]) al_q[k][i] <= stg_data[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (commit_en && commit_sect == SEC_CTL) begin
      for (int i = 0; i < CTL_N; i++)
        if (stg_mask[i]) ctl_q[i] <= stg_data[i];
    end
  end
endmodule

// File: rtl/ccr_time_keeper.sv
module ccr_time_keeper
  import ccr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     snap_en,
  input  logic                     commit_en,
  input  logic [PAGE-1:0][DW-1:0]  stg_data,
  input  logic [PAGE-1:0]          stg_mask,
  output logic [PAGE-1:0][DW-1:0]  tm_q,
  output logic [PAGE-1:0][DW-1:0]  snap_q
);
  logic [DW:0] sec_s, min_s, hr_s;

  always_comb begin
    sec_s = bcd_step(tm_q[0], LIM_SM);
    min_s = bcd_step(tm_q[1], LIM_SM);
    hr_s  = bcd_step({2'b00, tm_q[2][5:0]}, LIM_HR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm_q           <= '0;
      tm_q[CENT_IDX] <= CENT_RST;
    end else if (commit_en) begin
      for (int i = 0; i < PAGE; i++)
        if (stg_mask[i]) tm_q[i] <= stg_data[i];
    end else if (tick) begin
      tm_q[0] <= sec_s[DW-1:0];
      if (sec_s[DW]) begin
        tm_q[1] <= min_s[DW-1:0];
        if (min_s[DW]) tm_q[2] <= {tm_q[2][7:6], hr_s[5:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (snap_en) snap_q <= tm_q;
  end
endmodule

// File: rtl/ccr_status_reg.sv
module ccr_status_reg
  import ccr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stat_wr,
  input  logic       wr_wel,
  input  logic       wr_rwel,
  input  logic       time_wr,
  output logic       wel,
  output logic       rwel,
  output logic       rtcf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      rwel <= 1'b0;
    end else if (stat_wr) begin
      wel  <= wr_wel;
      rwel <= wr_rwel & wr_wel & wel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rtcf <= 1'b1;
    else if (time_wr) rtcf <= 1'b0;
  end
endmodule

// File: rtl/ccr_access_ctrl.sv
module ccr_access_ctrl
  import ccr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txn_start,
  input  logic          txn_read,
  input  logic          txn_use_addr,
  input  logic [5:0]    txn_addr,
  input  logic          txn_stop,
  input  logic          wd_valid,
  input  logic [7:0]    wd_data,
  output logic          wd_ready,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  input  logic          rd_ready,
  input  logic          sec_tick,
  input  logic [2:0]    ext_flags
);
  logic            act_q, is_rd_q, done_q;
  logic [AW-1:0]   cur_addr;
  sect_e           cur_sect;
  logic            stop_ev, wr_hs, rd_hs, commit_go;
  logic            nv_commit, time_commit, stat_commit;

  logic [PAGE-1:0][DW-1:0]               stg_data;
  logic [PAGE-1:0]                       stg_mask;
  sect_e                                 stg_sect;
  logic [N_ALARMS-1:0][PAGE-1:0][DW-1:0] al_q;
  logic [CTL_N-1:0][DW-1:0]              ctl_q;
  logic [PAGE-1:0][DW-1:0]               tm_q, snap_q;
  logic                                  wel, rwel, rtcf;

  assign cur_sect = sect_of(cur_addr);
  assign stop_ev  = txn_stop & ~txn_start & act_q;
  assign wd_ready = act_q & ~is_rd_q & ~done_q & ~txn_start & ~txn_stop;
  assign rd_valid = act_q &  is_rd_q & ~done_q & ~txn_start & ~txn_stop;
  assign wr_hs    = wd_valid & wd_ready;
  assign rd_hs    = rd_valid & rd_ready;

  // transaction state and address pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      is_rd_q  <= 1'b0;
      done_q   <= 1'b0;
      cur_addr <= '0;
    end else if (txn_start) begin
      act_q   <= 1'b1;
      is_rd_q <= txn_read;
      done_q  <= 1'b0;
      if (txn_use_addr) cur_addr <= txn_addr;
    end else if (stop_ev) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (wr_hs || rd_hs) begin
      cur_addr <= next_addr(cur_addr);
      if (cur_sect == SEC_STAT) done_q <= 1'b1;
    end
  end

  ccr_stage_buf #(.DEPTH(PAGE)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (txn_start | stop_ev),
    .wr_en   (wr_hs && cur_sect != SEC_NONE),
    .idx     (cur_addr[IW-1:0]),
    .wdata   (wd_data),
    .sect_in (cur_sect),
    .data_q  (stg_data),
    .mask_q  (stg_mask),
    .sect_q  (stg_sect)
  );

  assign commit_go   = stop_ev & ~is_rd_q & (|stg_mask);
  assign nv_commit   = commit_go & wel & rwel &
                       (stg_sect == SEC_AL0 || stg_sect == SEC_AL1 || stg_sect == SEC_CTL);
  assign time_commit = commit_go & wel & rwel & (stg_sect == SEC_TIME);
  assign stat_commit = commit_go & (stg_sect == SEC_STAT);

  ccr_nv_bank u_nv (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_en   (nv_commit),
    .commit_sect (stg_sect),
    .stg_data    (stg_data),
    .stg_mask    (stg_mask),
    .al_q        (al_q),
    .ctl_q       (ctl_q)
  );

  ccr_time_keeper u_time (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sec_tick),
    .snap_en   (txn_start & txn_read),
    .commit_en (time_commit),
    .stg_data  (stg_data),
    .stg_mask  (stg_mask),
    .tm_q      (tm_q),
    .snap_q    (snap_q)
  );

  ccr_status_reg u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_wr (stat_commit),
    .wr_wel  (stg_data[PAGE-1][WEL_BIT]),
    .wr_rwel (stg_data[PAGE-1][RWEL_BIT]),
    .time_wr (time_commit),
    .wel     (wel),
    .rwel    (rwel),
    .rtcf    (rtcf)
  );

  always_comb begin
    case (cur_sect)
      SEC_AL0, SEC_AL1: rd_data = al_q[cur_addr[IW]][cur_addr[IW-1:0]];
      SEC_CTL:          rd_data = ctl_q[cur_addr[CW-1:0]];
      SEC_TIME:         rd_data = snap_q[cur_addr[IW-1:0]];
      SEC_STAT:         rd_data = {ext_flags, 2'b00, rwel, wel, rtcf};
      default:          rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ccr_access_chk.sv
module ccr_access_chk
  import ccr_pkg::*;
(
  input logic                                    clk,
  input logic                                    rst_n,
  input logic                                    txn_start,
  input logic                                    txn_stop,
  input logic                                    wd_valid,
  input logic                                    wd_ready,
  input logic                                    rd_valid,
  input logic                                    rd_ready,
  input logic                                    act_q,
  input logic                                    is_rd_q,
  input logic [AW-1:0]                           cur_addr,
  input logic [PAGE-1:0]                         stg_mask,
  input logic [PAGE-1:0][DW-1:0]                 snap_q,
  input logic [N_ALARMS-1:0][PAGE-1:0][DW-1:0]   al_q,
  input logic [CTL_N-1:0][DW-1:0]                ctl_q,
  input logic                                    wel,
  input logic                                    rwel
);
  assert_stay_in_section_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((wd_valid && wd_ready) || (rd_valid && rd_ready)) && sect_of(cur_addr) != SEC_NONE
    |=> sect_of(cur_addr) == $past(sect_of(cur_addr)));

  assert_status_one_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((wd_valid && wd_ready) || (rd_valid && rd_ready)) && cur_addr == STAT_ADDR
    |=> !wd_ready && !rd_valid);

  assert_no_unlocked_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(txn_stop && wel && rwel) |=> $stable(al_q) && $stable(ctl_q));

  assert_rwel_implies_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rwel |-> wel);

  assert_snapshot_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && is_rd_q && !txn_start |=> $stable(snap_q));

  assert_abort_clears_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |=> stg_mask == '0);

  assert_backpressure_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) || (wd_ready && !wd_valid) |=> $stable(cur_addr));
endmodule

bind ccr_access_ctrl ccr_access_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .txn_start (txn_start),
  .txn_stop  (txn_stop),
  .wd_valid  (wd_valid),
  .wd_ready  (wd_ready),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .act_q     (act_q),
  .is_rd_q   (is_rd_q),
  .cur_addr  (cur_addr),
  .stg_mask  (stg_mask),
  .snap_q    (snap_q),
  .al_q      (al_q),
  .ctl_q     (ctl_q),
  .wel       (wel),
  .rwel      (rwel)
);

// File: tb/sim_ccr_access_ctrl.sv
module sim_ccr_access_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic txn_start = 0, txn_read = 0, txn_use_addr = 0, txn_stop = 0;
  logic [5:0] txn_addr = '0;
  logic wd_valid = 0, wd_ready, rd_valid, rd_ready = 0, sec_tick = 0;
  logic [7:0] wd_data = '0, rd_data;
  logic [2:0] ext_flags = '0;

  int n_chk = 0, n_fail = 0;

  // bench model
  logic [7:0] m_reg [64];
  logic [7:0] stg [64];
  logic       stg_m [64];
  logic [7:0] m_snap [8];
  logic m_wel, m_rwel, m_rtcf, m_act, m_rd, m_done;
  logic [5:0] m_addr;

  always #2.5ns clk = ~clk;

  ccr_access_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_read(txn_read),
    .txn_use_addr(txn_use_addr), .txn_addr(txn_addr), .txn_stop(txn_stop),
    .wd_valid(wd_valid), .wd_data(wd_data), .wd_ready(wd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
    .sec_tick(sec_tick), .ext_flags(ext_flags)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // 0 alarm0, 1 alarm1, 2 control, 3 time, 4 status, 5 undefined
  function automatic int f_sect(input logic [5:0] a);
    if (a <= 6'h07) return 0;
    if (a <= 6'h0F) return 1;
    if (a <= 6'h13) return 2;
    if (a >= 6'h30 && a <= 6'h37) return 3;
    if (a == 6'h3F) return 4;
    return 5;
  endfunction

  function automatic logic [5:0] f_next(input logic [5:0] a);
    case (f_sect(a))
      0: return (a == 6'h07) ? 6'h00 : a + 6'd1;
      1: return (a == 6'h0F) ? 6'h08 : a + 6'd1;
      2: return (a == 6'h13) ? 6'h10 : a + 6'd1;
      3: return (a == 6'h37) ? 6'h30 : a + 6'd1;
      4: return 6'h3F;
      default: return a + 6'd1;
    endcase
  endfunction

  function automatic logic [8:0] f_step(input logic [7:0] v, input logic [7:0] lim);
    logic [3:0] hi, lo;
    hi = v[7:4]; lo = v[3:0];
    if (v == lim) return 9'h100;
    if (lo == 4'h9) return {1'b0, hi + 4'h1, 4'h0};
    return {1'b0, v + 8'h01};
  endfunction

  function automatic logic [7:0] exp_read(input logic [5:0] a);
    case (f_sect(a))
      3: return m_snap[a - 6'h30];
      4: return {ext_flags, 2'b00, m_rwel, m_wel, m_rtcf};
      5: return 8'h00;
      default: return m_reg[a];
    endcase
  endfunction

  task automatic t_start(input logic rd, input logic use_a, input logic [5:0] a);
    @(negedge clk);
    txn_start = 1; txn_read = rd; txn_use_addr = use_a; txn_addr = a;
    for (int i = 0; i < 64; i++) stg_m[i] = 0;
    m_act = 1; m_rd = rd; m_done = 0;
    if (use_a) m_addr = a;
    if (rd) for (int i = 0; i < 8; i++) m_snap[i] = m_reg[6'h30 + i];
    @(negedge clk);
    txn_start = 0;
  endtask

  task automatic t_stop();
    logic [7:0] d;
    @(negedge clk);
    txn_stop = 1;
    if (m_act && !m_rd) begin
      if (stg_m[63]) begin
        d = stg[63];
        m_rwel = d[2] & d[1] & m_wel;
        m_wel  = d[1];
      end else if (m_wel && m_rwel) begin
        for (int a = 0; a < 64; a++)
          if (stg_m[a]) begin
            m_reg[a] = stg[a];
            if (a >= 48 && a <= 55) m_rtcf = 0;
          end
      end
    end
    for (int i = 0; i < 64; i++) stg_m[i] = 0;
    m_act = 0;
    @(negedge clk);
    txn_stop = 0;
  endtask

  task automatic t_wr(input logic [7:0] d, input string tag);
    logic er;
    @(negedge clk);
    wd_valid = 1; wd_data = d;
    er = m_act && !m_rd && !m_done;
    chk(tag, wd_ready, er);
    if (er) begin
      if (f_sect(m_addr) != 5) begin stg[m_addr] = d; stg_m[m_addr] = 1; end
      if (f_sect(m_addr) == 4) m_done = 1;
      m_addr = f_next(m_addr);
    end
    @(negedge clk);
    wd_valid = 0;
  endtask

  task automatic t_rd(input int stall, input string tag);
    logic ev;
    logic [7:0] e;
    @(negedge clk);
    ev = m_act && m_rd && !m_done;
    chk({tag, " valid"}, rd_valid, ev);
    if (ev) begin
      e = exp_read(m_addr);
      repeat (stall) @(negedge clk);
      chk({tag, " data"}, rd_data, e);
      rd_ready = 1;
      if (f_sect(m_addr) == 4) m_done = 1;
      m_addr = f_next(m_addr);
      @(negedge clk);
      rd_ready = 0;
    end
  endtask

  task automatic t_tick();
    logic [8:0] s, m, h;
    @(negedge clk);
    sec_tick = 1;
    s = f_step(m_reg[48], 8'h59);
    m_reg[48] = s[7:0];
    if (s[8]) begin
      m = f_step(m_reg[49], 8'h59);
      m_reg[49] = m[7:0];
      if (m[8]) begin
        h = f_step({2'b00, m_reg[50][5:0]}, 8'h23);
        m_reg[50] = {m_reg[50][7:6], h[5:0]};
      end
    end
    @(negedge clk);
    sec_tick = 0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    int seed;
    int kind, len;
    logic [5:0] a;
    seed = 32'h1234_5A5A;
    void'($urandom(seed));
    for (int i = 0; i < 64; i++) begin m_reg[i] = 0; stg[i] = 0; stg_m[i] = 0; end
    m_reg[55] = 8'h20;
    m_wel = 0; m_rwel = 0; m_rtcf = 1; m_act = 0; m_rd = 0; m_done = 0; m_addr = 0;
    for (int i = 0; i < 8; i++) m_snap[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12: idle outputs and reset contents
    @(negedge clk);
    chk("R12 idle wd_ready", wd_ready, 0);
    chk("R12 idle rd_valid", rd_valid, 0);
    t_start(1, 0, 6'h00);
    for (int i = 0; i < 9; i++) t_rd(0, "R12 alarm0 reset + R2 wrap");
    t_stop();
    t_start(1, 1, 6'h34);
    for (int i = 0; i < 5; i++) t_rd(0, "R12 time reset + R2 wrap at 0x37");
    t_stop();
    t_start(1, 1, 6'h3F);
    t_rd(0, "R11 status after reset");
    t_rd(0, "R4 second status read blocked");
    t_stop();

    // R5: locked writes are discarded
    t_start(0, 1, 6'h02);
    t_wr(8'hAA, "R9 write ready"); t_wr(8'hBB, "R9 write ready");
    t_stop();
    t_start(1, 1, 6'h02);
    t_rd(0, "R5 locked write dropped"); t_rd(0, "R5 locked write dropped");
    t_stop();

    // R6: unlock sequence
    t_start(0, 1, 6'h3F); t_wr(8'h02, "R6 wel write"); t_stop();
    t_start(0, 1, 6'h3F); t_wr(8'h06, "R6 rwel write");
    t_wr(8'h00, "R4 second status byte refused");
    t_stop();
    t_start(1, 1, 6'h3F); t_rd(0, "R6 both enables set"); t_stop();

    // R2: page write wrapping in alarm bank 1
    t_start(0, 1, 6'h0E);
    for (int i = 0; i < 10; i++) t_wr(8'h40 + 8'(i), "R2 page write");
    t_stop();
    t_start(1, 1, 6'h08);
    for (int i = 0; i < 9; i++) t_rd(1, "R2 alarm1 wrapped contents");
    t_stop();

    // R8: abort discards staged bytes
    t_start(0, 1, 6'h11);
    t_wr(8'h5C, "R9 write ready"); t_wr(8'h5D, "R9 write ready");
    t_start(1, 1, 6'h10);
    for (int i = 0; i < 5; i++) t_rd(0, "R8 aborted control write");
    t_stop();

    // R1: undefined region
    t_start(0, 1, 6'h20); t_wr(8'hEE, "R1 undefined write"); t_stop();
    t_start(1, 1, 6'h1F);
    for (int i = 0; i < 3; i++) t_rd(0, "R1 undefined read zero");
    t_stop();
    t_start(1, 0, 6'h00); t_rd(0, "R3 current address after undefined"); t_stop();

    // R11 + R10 + R7: time write, snapshot during ticks, carry chain
    ext_flags = 3'b101;
    t_start(0, 1, 6'h30);
    t_wr(8'h58, "R9 write ready"); t_wr(8'h59, "R9 write ready"); t_wr(8'h23, "R9 write ready");
    t_stop();
    t_start(1, 1, 6'h30);
    t_tick(); t_tick(); t_tick();
    for (int i = 0; i < 3; i++) t_rd(0, "R7 snapshot holds during ticks");
    t_stop();
    t_start(1, 1, 6'h30);
    for (int i = 0; i < 3; i++) t_rd(0, "R10 carry chain rolled");
    t_stop();
    t_start(1, 1, 6'h3F); t_rd(0, "R11 status flags and cleared rtcf"); t_stop();

    // R3: current-address read continues
    t_start(1, 1, 6'h31); t_rd(0, "R3 read"); t_rd(0, "R3 read"); t_stop();
    t_start(1, 0, 6'h00); t_rd(0, "R3 continue at last plus one"); t_stop();

    // R6: other status write clears both
    t_start(0, 1, 6'h3F); t_wr(8'h04, "R6 odd status write"); t_stop();
    t_start(1, 1, 6'h3F); t_rd(0, "R6 rwel cleared"); t_stop();
    t_start(0, 1, 6'h00); t_wr(8'h99, "R9 write ready"); t_stop();
    t_start(1, 1, 6'h00); t_rd(0, "R5 write after relock dropped"); t_stop();

    // random phase
    for (int n = 0; n < 400; n++) begin
      kind = $urandom_range(0, 7);
      len  = $urandom_range(1, 10);
      case ($urandom_range(0, 5))
        0: a = 6'($urandom_range(0, 7));
        1: a = 6'($urandom_range(8, 15));
        2: a = 6'($urandom_range(16, 19));
        3: a = 6'($urandom_range(48, 55));
        4: a = 6'h3F;
        default: a = 6'($urandom_range(0, 63));
      endcase
      ext_flags = 3'($urandom_range(0, 7));
      case (kind)
        0, 1: begin
          t_start(1, 1, a);
          for (int i = 0; i < len; i++) t_rd($urandom_range(0, 3), "R9 random read");
          t_stop();
        end
        2, 3: begin
          t_start(0, 1, a);
          for (int i = 0; i < len; i++) t_wr(8'($urandom), "R9 random write");
          t_stop();
        end
        4: begin
          t_start(0, 1, 6'h3F);
          case ($urandom_range(0, 2))
            0: t_wr(8'h02, "R6 random wel");
            1: t_wr(8'h06, "R6 random rwel");
            default: t_wr(8'($urandom), "R6 random status");
          endcase
          t_stop();
        end
        5: begin
          t_start(1, 0, 6'h00);
          for (int i = 0; i < len; i++) t_rd(0, "R3 random current read");
          t_stop();
        end
        6: begin
          t_start(0, 1, a);
          t_wr(8'($urandom), "R8 random abort");
          t_start(1, 1, a);
          t_rd(0, "R8 random abort read");
          t_stop();
        end
        default: t_tick();
      endcase
    end

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule